// File: doc/BRIEF.md
# Prescaled Real-Time Seconds Counter

This block keeps elapsed time. A slow-clock enable input, one cycle wide and synchronous to the system clock, feeds a programmable prescaler. Each time the prescaler has seen a full period of enables, a 20-bit count advances by one. With the reset divisor and a 32.768 kHz enable rate, the count advances once per second. It runs for just over twelve days before it wraps back to zero.

Software reaches the block through a small register port. One location holds the prescale divisor, which software can read and write. The other location holds the running count and is read-only. The count moves independently of any reader, so software confirms a value by reading it twice and keeping it only when both reads agree. A one-cycle pulse output marks every advance of the count.

Top module: `rt_seconds_counter`

## Requirements
- R1: After reset, the count reads 0 and the divisor reads 0x8000.
- R2: Address 0 holds the divisor in bits [15:0] and can be read and written. Address 1 holds the count in bits [19:0]. Unused read bits are 0.
- R3: With divisor N, the count advances by exactly one after every N slow-clock enables, and never at any other time.
- R4: A divisor of 0 behaves as 65536.
- R5: After the count reaches 2^CNT_W-1, the next advance takes it to 0.
- R6: Writing the divisor leaves the count unchanged and restarts the prescaler from zero, so enables seen before the write do not count toward the next advance.
- R7: The count location is read-only. A write to address 1 changes neither the count nor the divisor.
- R8: `inc_pulse` is high for one cycle in the same cycle the new count value becomes visible. It is high at no other time.
- R9: `bus_rdata` shows the addressed value one cycle after `bus_rd` and holds it until the next read. Two reads with no advance between them return the same count.
- R10: With the reset divisor, 32767 enables leave the count at 0 and the 32768th enable advances it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slck_en | input | 1 | One-cycle slow-clock enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 = divisor, 1 = count |
| bus_wdata | input | DATA_W | Write data; the divisor takes bits [15:0] |
| bus_rdata | output | DATA_W | Registered read data |
| inc_pulse | output | 1 | One-cycle pulse on each count advance |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never asserted in the same cycle. They also assume that `slck_en` is a clean synchronous strobe with no relation to bus activity. The stimulus issues every access in its own cycle and keeps the enable low during writes. After a burst of enables, it waits several cycles before reading, so no advance is pending when the count is compared. A second instance with a 10-bit count reaches the wrap point within the run.

// File: rtl/rtsc_pkg.sv
package rtsc_pkg;
  typedef enum logic {
    ADDR_DIV = 1'b0,
    ADDR_CNT = 1'b1
  } rtsc_addr_e;
endpackage

// File: rtl/rtsc_regs.sv
module rtsc_regs
  import rtsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W = 20,
  parameter int DIV_W = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  output logic [DIV_W-1:0]  div_q,
  output logic              div_load,
  output logic [DATA_W-1:0] rdata
);
  // A write to the divisor location loads the divisor and restarts the prescaler.
  assign div_load = wr && (rtsc_addr_e'(addr) == ADDR_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= DIV_RESET;
    end else if (div_load) begin
      div_q <= wdata[DIV_W-1:0];
    end
  end

  // Registered read data. It holds its value between reads.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      if (rtsc_addr_e'(addr) == ADDR_DIV) rdata <= DATA_W'(div_q);
      else                                rdata <= DATA_W'(count);
    end
  end
endmodule

// File: rtl/rtsc_prescaler.sv
module rtsc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slck_en,
  input  logic             load,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] last;

  // A divisor of zero wraps to all ones, which gives a 2^DIV_W period.
  assign last = div - DIV_W'(1);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      phase_q <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= slck_en && (phase_q == last);
      if (slck_en) phase_q <= (phase_q == last) ? '0 : phase_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/rtsc_counter.sv
module rtsc_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             inc_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      inc_pulse <= 1'b0;
    end else begin
      inc_pulse <= tick;
      if (tick) count <= count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rt_seconds_counter.sv
module rt_seconds_counter #(
  parameter int DATA_W = 32,
  parameter int CNT_W = 20,
  parameter int DIV_W = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slck_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              inc_pulse
);
  logic [DIV_W-1:0] div_q;
  logic             div_load;
  logic             tick;
  logic [CNT_W-1:0] count_q;

  rtsc_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .count(count_q), .div_q(div_q),
    .div_load(div_load), .rdata(bus_rdata)
  );

  rtsc_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .slck_en(slck_en), .load(div_load),
    .div(div_q), .tick(tick)
  );

  rtsc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .count(count_q), .inc_pulse(inc_pulse)
  );
endmodule

// File: rtl/rtsc_checker.sv
module rtsc_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W = 20,
  parameter int DIV_W = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'h8000
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              inc_pulse,
  input logic [CNT_W-1:0]  count,
  input logic [DIV_W-1:0]  div,
  input logic              tick
);
  // R1: reset values
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (count == '0) && (div == DIV_RESET));

  // R2: a divisor write is stored
  a_r2_div_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr) |=> div == $past(bus_wdata[DIV_W-1:0]));

  // R6: a write restarts the prescaler, and the count stays put on the following edge
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr) |=> !tick);
  a_r6_count_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr) |-> ##2 $stable(count));

  // R7: a write to the count location leaves the divisor untouched
  a_r7_read_only: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr) |=> $stable(div));

  // R8 and R5: the count only ever steps by one (wrapping), together with the pulse
  a_r8_pulse_step: assert property (@(posedge clk) disable iff (rst)
    inc_pulse |-> count == $past(count) + CNT_W'(1));
  a_r8_no_pulse_hold: assert property (@(posedge clk) disable iff (rst)
    !inc_pulse |-> $stable(count));

  // R9: the count read returns the sampled count
  a_r9_read_count: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr) |=> bus_rdata == DATA_W'($past(count)));
endmodule

bind rt_seconds_counter rtsc_checker #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .inc_pulse(inc_pulse),
  .count(count_q), .div(div_q), .tick(tick)
);

// File: tb/rt_seconds_counter_bench.sv
`timescale 1ns/1ps
module rt_seconds_counter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slck_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_main, rdata_small;
  logic        inc_main, inc_small;
  int          total = 0;
  int          bad = 0;
  int          inc_seen = 0;

  always #2.5 clk = ~clk;

  rt_seconds_counter u_rt_seconds_counter (
    .clk(clk), .rst(rst), .slck_en(slck_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_main),
    .inc_pulse(inc_main)
  );

  // Narrow count so that the wrap is reachable.
  rt_seconds_counter #(.CNT_W(10)) u_rt_seconds_counter_small (
    .clk(clk), .rst(rst), .slck_en(slck_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_small),
    .inc_pulse(inc_small)
  );

  always @(negedge clk) if (inc_main) inc_seen++;

  // Vectors: {divisor, enables, expected advance}
  localparam logic [47:0] VEC [6] = '{
    {16'd1, 16'd5,  16'd5},
    {16'd2, 16'd7,  16'd3},
    {16'd3, 16'd9,  16'd3},
    {16'd5, 16'd14, 16'd2},
    {16'd4, 16'd3,  16'd0},
    {16'd7, 16'd21, 16'd3}
  };

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [31:0] m, output logic [31:0] s);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    m = rdata_main; s = rdata_small;
  endtask

  task automatic pulses(input int n);
    @(negedge clk);
    slck_en = 1'b1;
    repeat (n) @(negedge clk);
    slck_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] m, s, m2, s2, base;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1
    reg_read(1'b0, m, s);  check("R1 divisor", m, 32'h8000);
    reg_read(1'b1, m, s);  check("R1 count", m, 0);

    // R10: reset divisor gives one advance per 32768 enables
    pulses(32767);
    reg_read(1'b1, m, s);  check("R10 before", m, 0);
    pulses(1);
    reg_read(1'b1, m, s);  check("R10 after", m, 1);

    // R3 and R8: vector table
    foreach (VEC[i]) begin
      reg_write(1'b0, 32'(VEC[i][47:32]));
      reg_read(1'b1, base, s);
      inc_seen = 0;
      pulses(int'(VEC[i][31:16]));
      reg_read(1'b1, m, s);
      check("R3 advance", m - base, VEC[i][15:0]);
      check("R8 pulse count", inc_seen, VEC[i][15:0]);
    end

    // R2: readback, upper bits zero
    reg_write(1'b0, 32'hABCD_1234);
    reg_read(1'b0, m, s);  check("R2 readback", m, 32'h1234);

    // R9: two reads with no advance agree
    reg_read(1'b1, m, s);
    reg_read(1'b1, m2, s2); check("R9 double read", m2, m);

    // R7: a write to the count location is ignored
    reg_write(1'b1, 32'h000F_FFFF);
    reg_read(1'b1, m2, s2); check("R7 count kept", m2, m);
    reg_read(1'b0, m2, s2); check("R7 divisor kept", m2, 32'h1234);

    // R6: a rewrite restarts the prescaler and keeps the count
    reg_write(1'b0, 32'd4);
    reg_read(1'b1, base, s);
    pulses(3);
    reg_write(1'b0, 32'd4);
    reg_read(1'b1, m, s);  check("R6 count kept", m, base);
    pulses(3);
    reg_read(1'b1, m, s);  check("R6 restart", m, base);
    pulses(1);
    reg_read(1'b1, m, s);  check("R6 advance", m, base + 1);

    // R4: divisor 0 acts as 65536
    reg_write(1'b0, 32'd0);
    reg_read(1'b0, m, s);  check("R4 readback", m, 0);
    reg_read(1'b1, base, s);
    pulses(65535);
    reg_read(1'b1, m, s);  check("R4 before", m, base);
    pulses(1);
    reg_read(1'b1, m, s);  check("R4 after", m, base + 1);

    // R5: wrap on the 10-bit instance
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    reg_write(1'b0, 32'd1);
    pulses(1023);
    reg_read(1'b1, m, s);  check("R5 at max", s, 1023);
    pulses(1);
    reg_read(1'b1, m, s);  check("R5 wrapped", s, 0);
    check("R5 wide count", m, 1024);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule